// File: doc/BRIEF.md
# 8080 Status-Latch System Controller

This block sits between an 8080-class CPU and the memory and I/O devices of the system. At the start of every machine cycle the CPU drives an 8-bit status word onto its data bus and pulses a status strobe low. The block stores that word. For the rest of the cycle it derives the active-low memory read, memory write, I/O read, I/O write and interrupt acknowledge commands from the stored word, combined with the CPU's read-enable, write and hold-acknowledge inputs.

The block also steers the 8-bit data path between the CPU side and the system side. Each tri-state port is modelled as a data output with its own output enable. Reads pass system data to the CPU, and writes pass CPU data to the system. A hold acknowledge that arrives during a read freezes the read data and withdraws the read command. A bus-off input takes the commands and both drivers off the bus at once, with no clock involved.

When vector injection is enabled, an interrupt acknowledge read returns all ones to the CPU, which is the single-byte restart-7 opcode. This lets a small system have one interrupt vector without an external instruction port. The parameter `ADV_WRITE` selects the write style. With it set, write commands follow the stored status directly. With it clear, they also require the CPU write strobe to be low.

Top module: `ctl8080_sysctl`

## Requirements
- R1: While `stat_stb_n` is low, every command output is high (inactive) and `cpu_d_oe` and `sys_d_oe` are low. At each clock edge that samples `stat_stb_n` low, the status word is taken from `cpu_d_in[7:0]`, so the value present in the last low cycle before the strobe rises is the one kept.
- R2: Status bits used: bit0 interrupt acknowledge, bit1 write-not (0 = write cycle), bit3 halt, bit4 output, bit6 input, bit7 memory read. `mem_rd_n` is low when stored bit7=1, bit3=0, bit0=0 and `cpu_rd` is high. This covers status words 8'hA2 (fetch), 8'h82 (memory read) and 8'h86 (stack read).
- R3: `io_rd_n` is low when stored bit6=1 (input read, 8'h42) and `cpu_rd` is high.
- R4: `int_ack_n` is low when stored bit0=1 (8'h23, or 8'h2B while halted) and `cpu_rd` is high, so each read pulse of a multi-byte acknowledge gives its own pulse. The halt word 8'h8A produces no command.
- R5: `mem_wr_n` is selected by bit1=0 with bit4=0 (8'h00, 8'h04), and `io_wr_n` by bit1=0 with bit4=1 (8'h10). With `ADV_WRITE`=0 the selected command is low only while `cpu_wr_n` is low. With `ADV_WRITE`=1 it is low for the whole cycle after the strobe.
- R6: `cpu_d_oe` equals `cpu_rd`, outside the strobe interval and when the bus is not off. While it is high, `cpu_d_out` carries `sys_d_in`.
- R7: `sys_d_oe` is high when the stored word is a write cycle (bit1=0), `cpu_rd` is low and the strobe is high. While it is high, `sys_d_out` carries `cpu_d_in`. `cpu_d_oe` and `sys_d_oe` are never high together.
- R8: If `hold_ack` is high while `cpu_rd` is high, all read commands go high in that same cycle. From the next cycle `cpu_d_out` keeps the `sys_d_in` value sampled at the first edge that saw both high, until `cpu_rd` falls.
- R9: While `bus_off` is high, `cmd_oe`, `sys_d_oe` and `cpu_d_oe` are low with no clock delay. When it returns low, normal operation resumes.
- R10: While `vec_inject_en` is high and the stored word selects interrupt acknowledge, `cpu_d_out` is 8'hFF whenever `cpu_d_oe` is high.
- R11: During and straight after reset, the stored word selects no command: all commands are high and no data port is driven while `cpu_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_stb_n | input | 1 | Status strobe, low during the sync interval |
| cpu_rd | input | 1 | CPU read enable, high when the CPU takes data in |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| hold_ack | input | 1 | CPU hold acknowledge |
| bus_off | input | 1 | High releases commands and data drivers |
| vec_inject_en | input | 1 | Enables all-ones opcode during interrupt acknowledge |
| cpu_d_in | input | DW | CPU-side data bus as seen by the block |
| cpu_d_out | output | DW | Data driven toward the CPU |
| cpu_d_oe | output | 1 | Enable for the CPU-side driver |
| sys_d_in | input | DW | System-side data bus as seen by the block |
| sys_d_out | output | DW | Data driven toward the system |
| sys_d_oe | output | 1 | Enable for the system-side driver |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| int_ack_n | output | 1 | Interrupt acknowledge command, active low |
| cmd_oe | output | 1 | Enable for the five command outputs |

## Verification
The collision that matters most is a hold acknowledge landing in the same cycle as an active read. The bench raises `hold_ack` in the middle of memory reads and of an interrupt acknowledge, and changes `sys_d_in` afterwards. The read command must drop in that very cycle, and the CPU-side data must then stay at the value captured at the freezing edge rather than follow the new system data. A second overlap comes from raising `cpu_rd` inside the strobe interval and from raising `bus_off` during reads and writes: the strobe or bus-off suppression must win over the read decode in the same cycle.

// File: rtl/ctl8080_pkg.sv
`timescale 1ns/1ps
package ctl8080_pkg;
   localparam int ST_W = 8;
   // positions of status flags inside the captured word
   localparam int B_INTA  = 0;
   localparam int B_WO_N  = 1;
   localparam int B_STACK = 2;
   localparam int B_HLTA  = 3;
   localparam int B_OUT   = 4;
   localparam int B_M1    = 5;
   localparam int B_INP   = 6;
   localparam int B_MEMRD = 7;
   // value held after reset: a read-type word that selects nothing
   localparam logic [ST_W-1:0] ST_RESET = 8'h02;

   typedef struct packed {
      logic mem_rd;
      logic mem_wr;
      logic io_rd;
      logic io_wr;
      logic int_ack;
      logic wr_cycle;
   } cyc_sel_t;
endpackage

// File: rtl/ctl8080_status_latch.sv
`timescale 1ns/1ps
module ctl8080_status_latch
   import ctl8080_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stat_stb_n,
   input  logic [DW-1:0]   cpu_d_in,
   output logic [ST_W-1:0] status,
   output logic            sync
);
   // the word seen in the last low-strobe cycle is the one that survives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status <= ST_RESET;
      else if (!stat_stb_n)
         status <= cpu_d_in[ST_W-1:0];
   end

   assign sync = ~stat_stb_n;

   generate
      if (DW > ST_W) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^cpu_d_in[DW-1:ST_W];
      end
   endgenerate
endmodule

// File: rtl/ctl8080_cycle_decode.sv
`timescale 1ns/1ps
module ctl8080_cycle_decode
   import ctl8080_pkg::*;
(
   input  logic [ST_W-1:0] status,
   output cyc_sel_t        sel
);
   logic is_write;
   logic unused_flags;

   assign is_write = ~status[B_WO_N];

   always_comb begin
      sel          = '0;
      sel.wr_cycle = is_write;
      // memory read excludes halt and interrupt acknowledge words
      sel.mem_rd   = status[B_MEMRD] & ~status[B_HLTA] & ~status[B_INTA] & ~is_write;
      sel.io_rd    = status[B_INP] & ~is_write;
      sel.int_ack  = status[B_INTA] & ~is_write;
      sel.io_wr    = is_write & status[B_OUT];
      sel.mem_wr   = is_write & ~status[B_OUT];
   end

   // stack and fetch flags carry no command of their own
   assign unused_flags = status[B_STACK] ^ status[B_M1];
endmodule

// File: rtl/ctl8080_cmd_gen.sv
`timescale 1ns/1ps
module ctl8080_cmd_gen
   import ctl8080_pkg::*;
#(
   parameter bit ADV_WRITE = 1'b0
) (
   input  cyc_sel_t sel,
   input  logic     sync,
   input  logic     cpu_rd,
   input  logic     cpu_wr_n,
   input  logic     hold_ack,
   input  logic     rd_frozen,
   input  logic     bus_off,
   output logic     mem_rd_n,
   output logic     mem_wr_n,
   output logic     io_rd_n,
   output logic     io_wr_n,
   output logic     int_ack_n,
   output logic     cmd_oe
);
   logic rd_window;
   logic wr_window;

   // reads need the CPU taking data, no hold and no frozen transfer
   assign rd_window = cpu_rd & ~hold_ack & ~rd_frozen & ~sync;

   generate
      if (ADV_WRITE) begin : g_adv_wr
         assign wr_window = ~sync;
      end else begin : g_gated_wr
         assign wr_window = ~sync & ~cpu_wr_n;
      end
   endgenerate

   assign mem_rd_n  = ~(sel.mem_rd  & rd_window);
   assign io_rd_n   = ~(sel.io_rd   & rd_window);
   assign int_ack_n = ~(sel.int_ack & rd_window);
   assign mem_wr_n  = ~(sel.mem_wr  & wr_window);
   assign io_wr_n   = ~(sel.io_wr   & wr_window);
   assign cmd_oe    = ~bus_off;
endmodule

// File: rtl/ctl8080_data_steer.sv
`timescale 1ns/1ps
module ctl8080_data_steer #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync,
   input  logic          cpu_rd,
   input  logic          hold_ack,
   input  logic          bus_off,
   input  logic          wr_cycle,
   input  logic          vec_hit,
   input  logic [DW-1:0] cpu_d_in,
   input  logic [DW-1:0] sys_d_in,
   output logic [DW-1:0] cpu_d_out,
   output logic          cpu_d_oe,
   output logic [DW-1:0] sys_d_out,
   output logic          sys_d_oe,
   output logic          rd_frozen
);
   localparam logic [DW-1:0] VEC_OPCODE = {DW{1'b1}};

   logic [DW-1:0] held_q;
   logic          frz_q;

   // first edge with hold during a read captures system data
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frz_q  <= 1'b0;
         held_q <= '0;
      end else if (!cpu_rd) begin
         frz_q  <= 1'b0;
      end else if (hold_ack && !frz_q) begin
         frz_q  <= 1'b1;
         held_q <= sys_d_in;
      end
   end

   assign rd_frozen = frz_q;

   always_comb begin
      if (vec_hit)
         cpu_d_out = VEC_OPCODE;
      else if (frz_q)
         cpu_d_out = held_q;
      else
         cpu_d_out = sys_d_in;
   end

   assign cpu_d_oe  = ~bus_off & ~sync & cpu_rd;
   assign sys_d_oe  = ~bus_off & ~sync & ~cpu_rd & wr_cycle;
   assign sys_d_out = cpu_d_in;
endmodule

// File: rtl/ctl8080_sysctl.sv
`timescale 1ns/1ps
module ctl8080_sysctl
   import ctl8080_pkg::*;
#(
   parameter int DW        = 8,
   parameter bit ADV_WRITE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stat_stb_n,
   input  logic          cpu_rd,
   input  logic          cpu_wr_n,
   input  logic          hold_ack,
   input  logic          bus_off,
   input  logic          vec_inject_en,
   input  logic [DW-1:0] cpu_d_in,
   output logic [DW-1:0] cpu_d_out,
   output logic          cpu_d_oe,
   input  logic [DW-1:0] sys_d_in,
   output logic [DW-1:0] sys_d_out,
   output logic          sys_d_oe,
   output logic          mem_rd_n,
   output logic          mem_wr_n,
   output logic          io_rd_n,
   output logic          io_wr_n,
   output logic          int_ack_n,
   output logic          cmd_oe
);
   generate
      if (DW < ST_W) begin : g_bad_width
         $error("ctl8080_sysctl: DW must hold a full status word");
      end
   endgenerate

   logic [ST_W-1:0] status;
   logic            sync;
   cyc_sel_t        sel;
   logic            rd_frozen;

   ctl8080_status_latch #(.DW(DW)) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .stat_stb_n (stat_stb_n),
      .cpu_d_in   (cpu_d_in),
      .status     (status),
      .sync       (sync)
   );

   ctl8080_cycle_decode u_decode (
      .status (status),
      .sel    (sel)
   );

   ctl8080_cmd_gen #(.ADV_WRITE(ADV_WRITE)) u_cmd (
      .sel       (sel),
      .sync      (sync),
      .cpu_rd    (cpu_rd),
      .cpu_wr_n  (cpu_wr_n),
      .hold_ack  (hold_ack),
      .rd_frozen (rd_frozen),
      .bus_off   (bus_off),
      .mem_rd_n  (mem_rd_n),
      .mem_wr_n  (mem_wr_n),
      .io_rd_n   (io_rd_n),
      .io_wr_n   (io_wr_n),
      .int_ack_n (int_ack_n),
      .cmd_oe    (cmd_oe)
   );

   ctl8080_data_steer #(.DW(DW)) u_steer (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync      (sync),
      .cpu_rd    (cpu_rd),
      .hold_ack  (hold_ack),
      .bus_off   (bus_off),
      .wr_cycle  (sel.wr_cycle),
      .vec_hit   (vec_inject_en & sel.int_ack),
      .cpu_d_in  (cpu_d_in),
      .sys_d_in  (sys_d_in),
      .cpu_d_out (cpu_d_out),
      .cpu_d_oe  (cpu_d_oe),
      .sys_d_out (sys_d_out),
      .sys_d_oe  (sys_d_oe),
      .rd_frozen (rd_frozen)
   );
endmodule

// File: rtl/ctl8080_sysctl_chk.sv
`timescale 1ns/1ps
module ctl8080_sysctl_chk #(
   parameter int DW        = 8,
   parameter bit ADV_WRITE = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          stat_stb_n,
   input logic          cpu_rd,
   input logic          cpu_wr_n,
   input logic          hold_ack,
   input logic          bus_off,
   input logic          vec_inject_en,
   input logic [DW-1:0] cpu_d_out,
   input logic          cpu_d_oe,
   input logic          sys_d_oe,
   input logic          mem_rd_n,
   input logic          mem_wr_n,
   input logic          io_rd_n,
   input logic          io_wr_n,
   input logic          int_ack_n,
   input logic          cmd_oe
);
   p_sync_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_stb_n |-> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n && int_ack_n && !cpu_d_oe && !sys_d_oe));

   p_read_needs_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |-> (mem_rd_n && io_rd_n && int_ack_n && !cpu_d_oe));

   p_one_driver_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_d_oe && sys_d_oe));

   p_hold_drops_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack |-> (mem_rd_n && io_rd_n && int_ack_n));

   p_hold_keeps_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_stb_n && $past(stat_stb_n) && cpu_rd && hold_ack && $past(cpu_rd && hold_ack)
       && $stable(vec_inject_en)) |-> $stable(cpu_d_out));

   p_bus_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_off |-> (!cmd_oe && !sys_d_oe && !cpu_d_oe));

   p_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_inject_en && !int_ack_n && cpu_d_oe) |-> (&cpu_d_out));

   generate
      if (!ADV_WRITE) begin : g_gated
         p_write_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!mem_wr_n || !io_wr_n) |-> !cpu_wr_n);
      end
   endgenerate
endmodule

bind ctl8080_sysctl ctl8080_sysctl_chk #(.DW(DW), .ADV_WRITE(ADV_WRITE)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .stat_stb_n    (stat_stb_n),
   .cpu_rd        (cpu_rd),
   .cpu_wr_n      (cpu_wr_n),
   .hold_ack      (hold_ack),
   .bus_off       (bus_off),
   .vec_inject_en (vec_inject_en),
   .cpu_d_out     (cpu_d_out),
   .cpu_d_oe      (cpu_d_oe),
   .sys_d_oe      (sys_d_oe),
   .mem_rd_n      (mem_rd_n),
   .mem_wr_n      (mem_wr_n),
   .io_rd_n       (io_rd_n),
   .io_wr_n       (io_wr_n),
   .int_ack_n     (int_ack_n),
   .cmd_oe        (cmd_oe)
);

// File: tb/test_ctl8080_sysctl.sv
`timescale 1ns/1ps
module test_ctl8080_sysctl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stat_stb_n = 1'b1, cpu_rd = 1'b0, cpu_wr_n = 1'b1, hold_ack = 1'b0;
   logic bus_off = 1'b0, vec_inject_en = 1'b0;
   logic [7:0] cpu_d_in = 8'h00, sys_d_in = 8'h00;
   logic [7:0] cpu_d_out, sys_d_out, a_cpu_d_out, a_sys_d_out;
   logic cpu_d_oe, sys_d_oe, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, int_ack_n, cmd_oe;
   logic a_cpu_d_oe, a_sys_d_oe, a_mem_rd_n, a_mem_wr_n, a_io_rd_n, a_io_wr_n, a_int_ack_n, a_cmd_oe;

   int n_chk = 0, n_fail = 0, inta_falls = 0;
   bit done = 0;

   always #4 clk = ~clk;

   ctl8080_sysctl #(.DW(8), .ADV_WRITE(1'b0)) i_ctl8080_sysctl (
      .clk(clk), .rst_n(rst_n), .stat_stb_n(stat_stb_n), .cpu_rd(cpu_rd), .cpu_wr_n(cpu_wr_n),
      .hold_ack(hold_ack), .bus_off(bus_off), .vec_inject_en(vec_inject_en),
      .cpu_d_in(cpu_d_in), .cpu_d_out(cpu_d_out), .cpu_d_oe(cpu_d_oe),
      .sys_d_in(sys_d_in), .sys_d_out(sys_d_out), .sys_d_oe(sys_d_oe),
      .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
      .int_ack_n(int_ack_n), .cmd_oe(cmd_oe));

   ctl8080_sysctl #(.DW(8), .ADV_WRITE(1'b1)) i_ctl8080_sysctl_adv (
      .clk(clk), .rst_n(rst_n), .stat_stb_n(stat_stb_n), .cpu_rd(cpu_rd), .cpu_wr_n(cpu_wr_n),
      .hold_ack(hold_ack), .bus_off(bus_off), .vec_inject_en(vec_inject_en),
      .cpu_d_in(cpu_d_in), .cpu_d_out(a_cpu_d_out), .cpu_d_oe(a_cpu_d_oe),
      .sys_d_in(sys_d_in), .sys_d_out(a_sys_d_out), .sys_d_oe(a_sys_d_oe),
      .mem_rd_n(a_mem_rd_n), .mem_wr_n(a_mem_wr_n), .io_rd_n(a_io_rd_n), .io_wr_n(a_io_wr_n),
      .int_ack_n(a_int_ack_n), .cmd_oe(a_cmd_oe));

   // reference model: cycle class 0 none, 1 mem read, 2 mem write, 3 io read, 4 io write, 5 int ack
   int m_cls = 0;
   bit m_wrc = 0, m_frz = 0;
   logic [7:0] m_held = 8'h00;

   function automatic int classify(input logic [7:0] s);
      case (s)
         8'hA2, 8'h82, 8'h86: return 1;
         8'h00, 8'h04:        return 2;
         8'h42:               return 3;
         8'h10:               return 4;
         8'h23, 8'h2B:        return 5;
         default:             return 0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cls = 0; m_wrc = 0; m_frz = 0; m_held = 8'h00;
      end else begin
         if (!cpu_rd) m_frz = 0;
         else if (hold_ack && !m_frz) begin m_frz = 1; m_held = sys_d_in; end
         if (!stat_stb_n) begin m_cls = classify(cpu_d_in); m_wrc = (cpu_d_in[1] == 1'b0); end
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit sync, rdok;
         logic [7:0] e_cpu;
         string t_rd, t_oe;
         sync = !stat_stb_n;
         rdok = cpu_rd && !hold_ack && !m_frz && !sync;
         t_rd = sync ? "R1" : (hold_ack || m_frz) ? "R8" : "R2";
         chk(t_rd, {7'd0, mem_rd_n}, {7'd0, !(m_cls == 1 && rdok)});
         chk(sync ? "R1" : "R3", {7'd0, io_rd_n}, {7'd0, !(m_cls == 3 && rdok)});
         chk(sync ? "R1" : "R4", {7'd0, int_ack_n}, {7'd0, !(m_cls == 5 && rdok)});
         chk("R5 gated mem write", {7'd0, mem_wr_n}, {7'd0, !(m_cls == 2 && !sync && !cpu_wr_n)});
         chk("R5 gated io write", {7'd0, io_wr_n}, {7'd0, !(m_cls == 4 && !sync && !cpu_wr_n)});
         chk("R5 advanced mem write", {7'd0, a_mem_wr_n}, {7'd0, !(m_cls == 2 && !sync)});
         chk("R5 advanced io write", {7'd0, a_io_wr_n}, {7'd0, !(m_cls == 4 && !sync)});
         chk("R9 cmd enable", {7'd0, cmd_oe}, {7'd0, !bus_off});
         t_oe = bus_off ? "R9" : sync ? "R1" : "R6";
         chk(t_oe, {7'd0, cpu_d_oe}, {7'd0, !bus_off && cpu_rd && !sync});
         chk(bus_off ? "R9" : "R7", {7'd0, sys_d_oe}, {7'd0, !bus_off && m_wrc && !cpu_rd && !sync});
         if (!bus_off && cpu_rd && !sync) begin
            e_cpu = (vec_inject_en && m_cls == 5) ? 8'hFF : m_frz ? m_held : sys_d_in;
            chk((vec_inject_en && m_cls == 5) ? "R10" : m_frz ? "R8" : "R6", cpu_d_out, e_cpu);
         end
         if (!bus_off && m_wrc && !cpu_rd && !sync) chk("R7 write data", sys_d_out, cpu_d_in);
      end
   end

   logic prev_inta = 1'b1;
   always @(negedge clk) begin
      if (prev_inta && !int_ack_n) inta_falls++;
      prev_inta = int_ack_n;
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic strobe(input logic [7:0] st);
      stat_stb_n = 1'b0; cpu_d_in = st; step();
      stat_stb_n = 1'b1; step();
   endtask

   task automatic mcycle(input logic [7:0] st, input int nrd, input logic [7:0] wdat);
      strobe(st);
      if (st[1] == 1'b0) begin
         cpu_d_in = wdat; step();
         cpu_wr_n = 1'b0; step(); step();
         cpu_wr_n = 1'b1; step();
      end else begin
         for (int i = 0; i < nrd; i++) begin
            sys_d_in = 8'($urandom); cpu_rd = 1'b1; step();
            sys_d_in = 8'($urandom); step();
            cpu_rd = 1'b0; step();
         end
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      end
   endtask

   initial begin
      #(8 * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] words [10] = '{8'hA2, 8'h82, 8'h00, 8'h86, 8'h04, 8'h42, 8'h10, 8'h23, 8'h8A, 8'h2B};
      repeat (3) step();
      @(negedge clk);
      // R11: reset state
      chk("R11 commands idle", {3'd0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, int_ack_n}, 8'h1F);
      chk("R11 drivers off", {6'd0, cpu_d_oe, sys_d_oe}, 8'h00);
      rst_n = 1'b1; step();
      @(negedge clk);
      chk("R11 after release", {2'd0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, int_ack_n, sys_d_oe}, 8'h3E);
      step();

      foreach (words[k]) mcycle(words[k], 1, 8'(k * 17 + 3));

      // R1: read enable raised inside the strobe interval
      stat_stb_n = 1'b0; cpu_d_in = 8'h82; cpu_rd = 1'b1; step();
      @(negedge clk);
      chk("R1 strobe suppresses read", {6'd0, mem_rd_n, cpu_d_oe}, 8'h02);
      stat_stb_n = 1'b1; step(); cpu_rd = 1'b0; step();

      // R4: three-byte acknowledge gives three pulses
      inta_falls = 0;
      mcycle(8'h23, 3, 8'h00);
      chk("R4 pulse count", 8'(inta_falls), 8'd3);

      // R10: vector injection
      vec_inject_en = 1'b1;
      strobe(8'h23);
      sys_d_in = 8'h5A; cpu_rd = 1'b1; step();
      @(negedge clk);
      chk("R10 vector byte", cpu_d_out, 8'hFF);
      cpu_rd = 1'b0; step();
      vec_inject_en = 1'b0;

      // R8: hold during memory read and interrupt acknowledge
      for (int j = 0; j < 2; j++) begin
         strobe(j == 0 ? 8'h82 : 8'h23);
         sys_d_in = 8'hC3; cpu_rd = 1'b1; step();
         hold_ack = 1'b1; step();
         @(negedge clk);
         chk("R8 read dropped", {6'd0, mem_rd_n, int_ack_n}, 8'h03);
         sys_d_in = 8'h3C; step();
         @(negedge clk);
         chk("R8 data frozen", cpu_d_out, 8'hC3);
         step();
         hold_ack = 1'b0; cpu_rd = 1'b0; step();
      end

      // R9: bus off during a read and a write
      strobe(8'h82);
      bus_off = 1'b1; cpu_rd = 1'b1; step();
      @(negedge clk);
      chk("R9 all released", {5'd0, cmd_oe, cpu_d_oe, sys_d_oe}, 8'h00);
      cpu_rd = 1'b0; step();
      strobe(8'h10);
      cpu_wr_n = 1'b0; step();
      @(negedge clk);
      chk("R9 write released", {6'd0, cmd_oe, sys_d_oe}, 8'h00);
      bus_off = 1'b0; step();
      @(negedge clk);
      chk("R9 resume", {6'd0, cmd_oe, sys_d_oe}, 8'h03);
      cpu_wr_n = 1'b1; step();

      // random mix of cycles with occasional hold and bus off
      for (int r = 0; r < 300; r++) begin
         hold_ack = ($urandom % 8) == 0;
         bus_off = ($urandom % 10) == 0;
         vec_inject_en = $urandom % 2;
         mcycle(words[$urandom % 10], 1 + $urandom % 2, 8'($urandom));
         hold_ack = 1'b0; bus_off = 1'b0;
      end

      step();
      summary();
      $finish;
   end
endmodule